// File: doc/BRIEF.md
# Eight-Channel PWM Timer with Paired Phase Mode

This block produces eight pulse-width-modulated outputs from one shared 16-bit up-counter. A clock-source field picks what advances the counter: nothing, every system clock, a fixed-rate tick input or an external tick input. A power-of-two prescaler thins that stream before it reaches the counter. The counter runs from zero up to a programmable period value and then returns to zero, so one PWM cycle lasts period + 1 counter steps.

Each channel normally drives an edge-aligned pulse that starts at the wrap and ends when the counter reaches that channel's compare value. A per-channel polarity bit inverts the output. Any even/odd channel pair can instead be joined: the even compare marks where the pulse begins, the odd compare marks where it ends, and the even output carries the shifted pulse while the odd output rests at its inactive level. Period and compare writes go to shadow copies that are copied into the working registers only at the counter wrap, so a period in progress is never cut short or stretched mid-pulse.

The counter start-up is governed by a two-state machine, HALT and RUN. HALT goes to RUN (transition START) on the clock edge after the source field is non-zero; RUN goes back to HALT (transition STOP) on the edge after the field returns to zero. Each channel pair uses one of two modes, SPLIT (independent) or JOINED (combined), picked by its combine bit.

Top module: `pwm_combo_timer`

## Requirements
- R1: After reset the counter reads 0, every output is low, source is off, the prescaler divides by 1, and all period, compare, polarity and combine values are 0.
- R2: Control register (address 0) bits [1:0] pick the source: 0 none, 1 every clock, 2 `fix_tick`, 3 `ext_tick`. With source 0 the counter holds its value and resumes from it later; counting begins no earlier than the second clock edge after the field becomes non-zero.
- R3: Control bits [4:2] hold k; the counter advances once per 2^k enabled source cycles, the step coming on the cycle where the low k bits of a free 7-bit source-cycle count (cleared by reset, advancing only while in RUN with the source enabled) are all ones.
- R4: On each step the counter adds 1, except that when it equals the working period (address 1) it returns to 0 (the wrap).
- R5: In SPLIT mode a channel is active while count < compare (address 8 + n); compare 0 gives never active and compare ≥ period gives always active; active is high when polarity is 0.
- R6: Polarity register (address 2) bit n inverts channel n from the clock after the write, with no wait for the wrap.
- R7: Combine register (address 3) bit 8·p selects JOINED mode for pair p (channels 2p and 2p+1) from the clock after the write.
- R8: In JOINED mode the even output is active while even compare ≤ count < odd compare, is never active if even compare ≥ odd compare, and the odd output stays at its inactive level.
- R9: Period and compare writes reach the working registers only at a wrap; a write on the same edge as a wrap waits for the next wrap.
- R10: Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate count enable, source 2 |
| ext_tick | input | 1 | External count enable, source 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 25 | Register write data |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 8 | Channel outputs |

## Verification
The compare set mixes zero, mid-range, exactly-period and above-period values, so one run separates the 0 %, partial and 100 % cases and catches an off-by-one at either end of the range. Joined pairs are tried with start below end and with start above end, which separates a correct window from a swapped or missing emptiness rule. The counter is driven by every source and by a non-trivial prescale with irregular tick patterns, which tells apart a divider that counts clocks from one that counts enabled cycles. A period shrink mid-cycle shows whether the shadow load waits for the wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned SRC_BITS  = 2;
    localparam int unsigned PS_BITS   = 3;
    localparam int unsigned DIV_BITS  = (1 << PS_BITS) - 1;
    localparam int unsigned PAIR_STEP = 8;

    localparam int unsigned ADR_CTRL   = 0;
    localparam int unsigned ADR_PERIOD = 1;
    localparam int unsigned ADR_POLAR  = 2;
    localparam int unsigned ADR_JOIN   = 3;

    typedef enum logic [SRC_BITS-1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    typedef enum logic {
        TS_HALT = 1'b0,
        TS_RUN  = 1'b1
    } tstate_e;

    typedef enum logic {
        PM_SPLIT  = 1'b0,
        PM_JOINED = 1'b1
    } pair_mode_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned CW  = 16,
    parameter int unsigned DW  = 25,
    parameter int unsigned AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic                    load,
    output src_e                    src,
    output logic [PS_BITS-1:0]      ps,
    output logic [NCH-1:0]          pol,
    output logic [NCH/2-1:0]        joined,
    output logic [CW-1:0]           period_act,
    output logic [NCH-1:0][CW-1:0]  cmp_act
);
    localparam int unsigned NPAIR = NCH / 2;

    logic [CW-1:0] period_sh;
    logic          unused_bits;

    assign unused_bits = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src        <= SRC_OFF;
            ps         <= '0;
            pol        <= '0;
            joined     <= '0;
            period_sh  <= '0;
            period_act <= '0;
        end else begin
            if (load) begin
                period_act <= period_sh;
            end
            if (wr_en) begin
                if (wr_addr == AW'(ADR_CTRL)) begin
                    src <= src_e'(wr_data[SRC_BITS-1:0]);
                    ps  <= wr_data[SRC_BITS +: PS_BITS];
                end
                if (wr_addr == AW'(ADR_PERIOD)) begin
                    period_sh <= wr_data[CW-1:0];
                end
                if (wr_addr == AW'(ADR_POLAR)) begin
                    pol <= wr_data[NCH-1:0];
                end
                if (wr_addr == AW'(ADR_JOIN)) begin
                    for (int p = 0; p < NPAIR; p++) begin
                        joined[p] <= wr_data[p*PAIR_STEP];
                    end
                end
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        logic          sel;
        logic [CW-1:0] sh;

        assign sel = wr_en && (wr_addr == AW'(NCH + c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh         <= '0;
                cmp_act[c] <= '0;
            end else begin
                if (load) begin
                    cmp_act[c] <= sh;
                end
                if (sel) begin
                    sh <= wr_data[CW-1:0];
                end
            end
        end
    end

    // Working copies move only on a wrap (R9)
    p_period_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(period_act));
    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_act));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               src,
    input  logic [PS_BITS-1:0] ps,
    input  logic               fix_tick,
    input  logic               ext_tick,
    output logic               tick
);
    tstate_e             state_q, state_d;
    logic [DIV_BITS-1:0] div_q;
    logic [DIV_BITS-1:0] mask;
    logic                src_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALT: if (src != SRC_OFF) state_d = TS_RUN;
            TS_RUN:  if (src == SRC_OFF) state_d = TS_HALT;
            default: state_d = TS_HALT;
        endcase
    end

    always_comb begin
        src_en = 1'b0;
        if (state_q == TS_RUN) begin
            unique case (src)
                SRC_OFF: src_en = 1'b0;
                SRC_SYS: src_en = 1'b1;
                SRC_FIX: src_en = fix_tick;
                SRC_EXT: src_en = ext_tick;
                default: src_en = 1'b0;
            endcase
        end
        mask = ~({DIV_BITS{1'b1}} << ps);
        tick = src_en && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (src_en) begin
            div_q <= div_q + 1'b1;
        end
    end

    // No step may come while the source field reads off (R2)
    p_no_tick_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OFF) |-> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = tick && (cnt == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // Steps between wraps add exactly one (R4)
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == CW'($past(cnt) + 1'b1)));
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cmp_e,
    input  logic [CW-1:0] cmp_o,
    input  logic          pol_e,
    input  logic          pol_o,
    input  logic          join_en,
    output logic          out_e,
    output logic          out_o
);
    pair_mode_e mode;
    logic       act_e, act_o;

    function automatic logic edge_active(input logic [CW-1:0] c,
                                         input logic [CW-1:0] value,
                                         input logic [CW-1:0] top);
        if (value == '0) return 1'b0;
        if (value >= top) return 1'b1;
        return c < value;
    endfunction

    assign mode = join_en ? PM_JOINED : PM_SPLIT;

    always_comb begin
        act_e = 1'b0;
        act_o = 1'b0;
        unique case (mode)
            PM_SPLIT: begin
                act_e = edge_active(cnt, cmp_e, period);
                act_o = edge_active(cnt, cmp_o, period);
            end
            PM_JOINED: begin
                act_e = (cnt >= cmp_e) && (cnt < cmp_o);
                act_o = 1'b0;
            end
            default: begin
                act_e = 1'b0;
                act_o = 1'b0;
            end
        endcase
    end

    assign out_e = act_e ^ pol_e;
    assign out_o = act_o ^ pol_o;

    // Odd channel rests while joined (R8)
    p_odd_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_en |-> (out_o == pol_o));
    // Empty joined window keeps the even output inactive (R8)
    p_empty_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (join_en && (cmp_e >= cmp_o)) |-> (out_e == pol_e));
    // Zero compare in split mode never activates (R5)
    p_zero_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!join_en && (cmp_e == '0)) |-> (out_e == pol_e));

endmodule

// File: rtl/pwm_combo_timer.sv
module pwm_combo_timer
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = $clog2(2 * NCH),
    parameter int unsigned DW  = ((NCH/2 - 1) * PAIR_STEP + 1 > CW) ?
                                 (NCH/2 - 1) * PAIR_STEP + 1 : CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fix_tick,
    input  logic           ext_tick,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [CW-1:0]  count_o,
    output logic [NCH-1:0] pwm_o
);
    localparam int unsigned NPAIR = NCH / 2;

    src_e                   src;
    logic [PS_BITS-1:0]     ps;
    logic [NCH-1:0]         pol;
    logic [NPAIR-1:0]       joined;
    logic [CW-1:0]          period_act;
    logic [NCH-1:0][CW-1:0] cmp_act;
    logic                   tick;
    logic                   wrap;
    logic [CW-1:0]          cnt;

    pwm_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load       (wrap),
        .src        (src),
        .ps         (ps),
        .pol        (pol),
        .joined     (joined),
        .period_act (period_act),
        .cmp_act    (cmp_act)
    );

    pwm_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .ps       (ps),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (period_act),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_pair #(.CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .period  (period_act),
            .cmp_e   (cmp_act[2*p]),
            .cmp_o   (cmp_act[2*p+1]),
            .pol_e   (pol[2*p]),
            .pol_o   (pol[2*p+1]),
            .join_en (joined[p]),
            .out_e   (pwm_o[2*p]),
            .out_o   (pwm_o[2*p+1])
        );
    end

    assign count_o = cnt;

    // Source off freezes the counter (R2)
    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OFF) |=> $stable(cnt));
    // Counter never passes the working period (R4)
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= period_act);

endmodule

// File: tb/sim_pwm_combo_timer.sv
module sim_pwm_combo_timer;

    localparam int NCH = 8;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int DW  = 25;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fix_tick = 1'b0;
    logic           ext_tick = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [CW-1:0]  count_o;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_src = 0, m_ps = 0, m_pre = 0, m_cnt = 0, m_run = 0;
    int m_mod_s = 0, m_mod_a = 0;
    int m_cv_s[NCH], m_cv_a[NCH];
    int m_pol = 0, m_join = 0;
    int m_en, m_tick, m_next_run;

    always #10 clk = ~clk;

    pwm_combo_timer u0 (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .pwm_o(pwm_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_out(input int ch);
        int a;
        int p;
        p = ch / 2;
        if ((m_join >> p) & 1) begin
            if (ch % 2 == 0) a = (m_cnt >= m_cv_a[ch] && m_cnt < m_cv_a[ch+1]) ? 1 : 0;
            else a = 0;
        end else if (m_cv_a[ch] == 0) a = 0;
        else if (m_cv_a[ch] >= m_mod_a) a = 1;
        else a = (m_cnt < m_cv_a[ch]) ? 1 : 0;
        return a ^ ((m_pol >> ch) & 1);
    endfunction

    function automatic string out_tag(input int ch);
        if ((m_join >> (ch / 2)) & 1) return (ch % 2 == 0) ? "R8" : "R7";
        if ((m_pol >> ch) & 1) return "R6";
        return "R5";
    endfunction

    function automatic string cnt_tag();
        if (m_ps != 0) return "R3";
        if (m_src != 1) return "R2";
        return "R4";
    endfunction

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_src = 0; m_ps = 0; m_pre = 0; m_cnt = 0; m_run = 0;
            m_mod_s = 0; m_mod_a = 0; m_pol = 0; m_join = 0;
            for (int i = 0; i < NCH; i++) begin m_cv_s[i] = 0; m_cv_a[i] = 0; end
        end else begin
            m_en = (m_run != 0) && ((m_src == 1) || (m_src == 2 && fix_tick) ||
                                    (m_src == 3 && ext_tick));
            m_tick = m_en && ((m_pre % (1 << m_ps)) == (1 << m_ps) - 1);
            if (m_en) m_pre = (m_pre + 1) % 128;
            if (m_tick) begin
                if (m_cnt == m_mod_a) begin
                    m_cnt = 0;
                    m_mod_a = m_mod_s;
                    for (int i = 0; i < NCH; i++) m_cv_a[i] = m_cv_s[i];
                end else m_cnt = m_cnt + 1;
            end
            m_next_run = (m_src != 0);
            m_run = m_next_run;
            if (wr_en) begin
                if (wr_addr == 0) begin m_src = wr_data & 3; m_ps = (wr_data >> 2) & 7; end
                else if (wr_addr == 1) m_mod_s = wr_data & 16'hFFFF;
                else if (wr_addr == 2) m_pol = wr_data & 8'hFF;
                else if (wr_addr == 3)
                    m_join = (wr_data[0]) | (wr_data[8] << 1) | (wr_data[16] << 2) | (wr_data[24] << 3);
                else if (wr_addr >= 8) m_cv_s[wr_addr - 8] = wr_data & 16'hFFFF;
            end
        end
        if (cyc > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // stimulus for the tick inputs and per-cycle comparison
    always @(negedge clk) begin
        fix_tick <= (cyc % 3 == 0);
        ext_tick <= (cyc % 5 == 1) || (cyc % 7 == 2);
        if (rst_n && !done) begin
            chk(count_o == CW'(m_cnt), cnt_tag(), count_o, m_cnt);
            for (int ch = 0; ch < NCH; ch++)
                chk(pwm_o[ch] == exp_out(ch)[0], out_tag(ch), pwm_o[ch], exp_out(ch));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int c0;
        int mx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count_o == 0, "R1 count", count_o, 0);
        chk(pwm_o == 0, "R1 outputs", pwm_o, 0);

        wr(1, 9);
        wr(8, 3);  wr(9, 0);  wr(10, 9);  wr(11, 12);
        wr(12, 5); wr(13, 8); wr(14, 7);  wr(15, 2);
        wr(0, 1);
        run(40);

        wr(2, 'h0F);          // R6 polarity
        run(30);
        wr(2, 0);

        wr(3, (1 << 16) | (1 << 24));  // R7/R8 joined pairs 2 and 3
        run(30);
        wr(3, 1);             // pair 0 start 3 end 0: empty window, R8
        run(22);
        wr(3, 0);
        run(5);

        // R9: shrink period mid-cycle; current cycle must still reach 9
        while (count_o != 2) @(negedge clk);
        wr(1, 4);
        mx = 0;
        do begin
            @(negedge clk);
            if (count_o > mx) mx = count_o;
        end while (count_o != 0);
        chk(mx == 9, "R9 old period kept", mx, 9);
        while (count_o != 4) @(negedge clk);
        @(negedge clk);
        chk(count_o == 0, "R9 new period", count_o, 0);
        wr(1, 9);

        wr(0, 1 | (2 << 2));  // R3 divide by 4
        run(100);

        wr(0, 0 | (2 << 2));  // R2 source off
        run(2);
        c0 = count_o;
        run(20);
        chk(count_o == CW'(c0), "R2 frozen", count_o, c0);
        wr(0, 1 | (2 << 2));
        run(40);

        wr(0, 2);             // fixed tick source
        run(60);
        wr(0, 3 | (1 << 2));  // external tick, divide by 2
        run(80);

        wr(0, 1);
        run(10);
        wr(5, 'h1FFFFFF);     // R10 unmapped
        wr(6, 'h1FFFFFF);
        wr(4, 0);
        wr(7, 'h155);
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++)
            chk(pwm_o[ch] == exp_out(ch)[0], "R10", pwm_o[ch], exp_out(ch));
        chk(count_o == CW'(m_cnt), "R10 count", count_o, m_cnt);
        run(30);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule